// File: doc/BRIEF.md
# Ping-Pong Byte Buffer Bridge

This block sits between a 16-bit host data port and the byte-wide side of a bus transfer engine. It holds two equal byte banks. At any moment one bank is mapped to the host and the other to the bus engine. A single-cycle flip command exchanges the two roles. Neither bank's contents change when the roles swap, so one side can fill a bank while the other side drains the second bank.

The host moves up to two bytes per access. The earlier byte travels in bits 7:0 and the later byte in bits 15:8. An odd transfer length is handled in two ways. The host can mark a write as single-byte. A read that finds only one byte left returns it in the low half with zero in the high half. The bus engine moves one byte per access on the alternate bank.

Three status outputs come straight from the two fill levels: the host bank is empty, the alternate bank is empty, and the host bank is full. A further output reports which bank is mapped to the host. The depth is a parameter and must be a power of two. A flip is expected only after the bus engine has finished with the alternate bank.

Top module: `pp_byte_bridge`

## Requirements
- R1: After reset both banks are empty, `host_full` is 0 and `host_bank` is 0.
- R2: A two-byte host write stores `host_wdata[7:0]` first and `host_wdata[15:8]` second, so after a flip the bus engine reads the low byte and then the high byte.
- R3: A host read when two or more bytes are held returns the oldest byte in `host_rdata[7:0]` and the next byte in `host_rdata[15:8]`, one cycle after `host_rd_en`, and removes both bytes.
- R4: A host read when exactly one byte is held returns that byte in `host_rdata[7:0]` with `host_rdata[15:8]` = 0, and leaves the bank empty.
- R5: A host write with `host_wr_one` = 1 stores only `host_wdata[7:0]`.
- R6: A `flip` pulse inverts `host_bank` on the next cycle and exchanges the roles of the banks; without a flip `host_bank` holds; the contents of both banks survive any number of flips.
- R7: `host_empty` and `alt_empty` are 1 exactly when the host-mapped and alternate banks, respectively, hold zero bytes.
- R8: `host_full` is 1 exactly when the host bank holds DEPTH bytes; bytes written beyond the free space are discarded (a two-byte write with one free slot keeps only the low byte).
- R9: A host read of an empty bank returns 0 and removes nothing.
- R10: Bus writes append one byte to the alternate bank; bus reads return its oldest byte one cycle after `bus_rd_en`, or 0 if that bank is empty.
- R11: Host-side and bus-side accesses in the same cycle act on their own banks without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flip | input | 1 | Swap host and bus bank roles |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_one | input | 1 | Host write carries only the low byte |
| host_wdata | input | 16 | Host write data, earlier byte in bits 7:0 |
| host_rd_en | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data, registered |
| bus_wr_en | input | 1 | Bus engine byte write strobe |
| bus_wdata | input | 8 | Bus engine write byte |
| bus_rd_en | input | 1 | Bus engine byte read strobe |
| bus_rdata | output | 8 | Bus engine read byte, registered |
| host_empty | output | 1 | Host-mapped bank holds no bytes |
| alt_empty | output | 1 | Alternate bank holds no bytes |
| host_full | output | 1 | Host-mapped bank holds DEPTH bytes |
| host_bank | output | 1 | Index of the bank mapped to the host |

## Verification
The properties checked on every cycle are these: the bank index toggles on each flip and holds otherwise, the two empty flags trade places across an idle flip, an empty read on either side returns zero, a full bank stays full under writes alone, and an idle alternate bank stays empty. Byte ordering, odd-length packing, partial acceptance at the full boundary and preservation of contents across flips all depend on byte values. Only the bench scenarios can show these, by comparing against a byte-level model of both banks under directed cases and random mixed traffic.

// File: rtl/pp_bridge_pkg.sv
package pp_bridge_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic              wr;
      logic              wr_two;
      logic [BYTE_W-1:0] b0;
      logic [BYTE_W-1:0] b1;
      logic              rd;
      logic              rd_two;
   } bank_req_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank
   import pp_bridge_pkg::*;
#(
   parameter int DEPTH = 512
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  bank_req_t                    req,
   output logic [BYTE_W-1:0]            peek0,
   output logic [BYTE_W-1:0]            peek1,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]     rp, wp;
   logic [CW-1:0]     cnt, free;
   logic [1:0]        acc, pop;

   always_comb begin
      free = CW'(DEPTH) - cnt;
      if (!req.wr)                          acc = 2'd0;
      else if (req.wr_two && free >= CW'(2)) acc = 2'd2;
      else if (free != '0)                  acc = 2'd1;
      else                                  acc = 2'd0;
      if (!req.rd)                          pop = 2'd0;
      else if (req.rd_two && cnt >= CW'(2))  pop = 2'd2;
      else if (cnt != '0)                   pop = 2'd1;
      else                                  pop = 2'd0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         wp  <= wp + AW'(acc);
         rp  <= rp + AW'(pop);
         cnt <= cnt + CW'(acc) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (acc != 2'd0) mem[wp] <= req.b0;
      if (acc == 2'd2) mem[wp + AW'(1)] <= req.b1;
   end

   assign peek0 = mem[rp];
   assign peek1 = mem[rp + AW'(1)];
   assign level = cnt;
endmodule

// File: rtl/pp_word_pack.sv
module pp_word_pack
   import pp_bridge_pkg::*;
#(
   parameter int LANES = 2,
   parameter int CW    = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [CW-1:0]           level,
   input  logic [LANES*BYTE_W-1:0] bytes_in,
   output logic [LANES*BYTE_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_en) begin
         for (int i = 0; i < LANES; i++)
            data_q[i*BYTE_W +: BYTE_W] <= (level > CW'(i)) ? bytes_in[i*BYTE_W +: BYTE_W] : '0;
      end
   end
endmodule

// File: rtl/pp_byte_bridge.sv
module pp_byte_bridge
   import pp_bridge_pkg::*;
#(
   parameter int DEPTH = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flip,
   input  logic          host_wr_en,
   input  logic          host_wr_one,
   input  logic [15:0]   host_wdata,
   input  logic          host_rd_en,
   output logic [15:0]   host_rdata,
   input  logic          bus_wr_en,
   input  logic [7:0]    bus_wdata,
   input  logic          bus_rd_en,
   output logic [7:0]    bus_rdata,
   output logic          host_empty,
   output logic          alt_empty,
   output logic          host_full,
   output logic          host_bank
);
   localparam int CW     = $clog2(DEPTH + 1);
   localparam int HLANES = 16 / BYTE_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pp_byte_bridge: DEPTH must be a power of two of at least 2");
   end

   logic              sel;
   bank_req_t         host_req, bus_req;
   bank_req_t         req   [2];
   logic [BYTE_W-1:0] pk0   [2];
   logic [BYTE_W-1:0] pk1   [2];
   logic [CW-1:0]     lvl   [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel <= 1'b0;
      else if (flip) sel <= ~sel;
   end

   always_comb begin
      host_req.wr     = host_wr_en;
      host_req.wr_two = ~host_wr_one;
      host_req.b0     = host_wdata[7:0];
      host_req.b1     = host_wdata[15:8];
      host_req.rd     = host_rd_en;
      host_req.rd_two = 1'b1;
      bus_req.wr      = bus_wr_en;
      bus_req.wr_two  = 1'b0;
      bus_req.b0      = bus_wdata;
      bus_req.b1      = '0;
      bus_req.rd      = bus_rd_en;
      bus_req.rd_two  = 1'b0;
   end

   for (genvar g = 0; g < 2; g++) begin : g_bank
      assign req[g] = (sel == 1'(g)) ? host_req : bus_req;
      pp_bank #(.DEPTH(DEPTH)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req[g]),
         .peek0 (pk0[g]),
         .peek1 (pk1[g]),
         .level (lvl[g])
      );
   end

   pp_word_pack #(.LANES(HLANES), .CW(CW)) u_host_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (host_rd_en),
      .level    (lvl[sel]),
      .bytes_in ({pk1[sel], pk0[sel]}),
      .data_q   (host_rdata)
   );

   pp_word_pack #(.LANES(1), .CW(CW)) u_bus_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd_en),
      .level    (lvl[~sel]),
      .bytes_in (pk0[~sel]),
      .data_q   (bus_rdata)
   );

   assign host_empty = (lvl[sel] == '0);
   assign alt_empty  = (lvl[~sel] == '0);
   assign host_full  = (lvl[sel] == CW'(DEPTH));
   assign host_bank  = sel;
endmodule

// File: rtl/pp_byte_bridge_chk.sv
module pp_byte_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        flip,
   input logic        host_wr_en,
   input logic        host_rd_en,
   input logic [15:0] host_rdata,
   input logic        bus_wr_en,
   input logic        bus_rd_en,
   input logic [7:0]  bus_rdata,
   input logic        host_empty,
   input logic        alt_empty,
   input logic        host_full,
   input logic        host_bank
);
   a_r6_flip_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> host_bank != $past(host_bank));

   a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !flip |=> host_bank == $past(host_bank));

   a_r6_idle_flip_swaps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (flip && !host_wr_en && !host_rd_en && !bus_wr_en && !bus_rd_en)
      |=> (host_empty == $past(alt_empty)) && (alt_empty == $past(host_empty)));

   a_r7_alt_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_empty && !bus_wr_en && !flip) |=> alt_empty);

   a_r8_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      host_full |-> !host_empty);

   a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (host_full && host_wr_en && !host_rd_en && !flip) |=> host_full);

   a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_empty) |=> host_rdata == 16'h0000);

   a_r9_empty_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_empty && !host_wr_en && !flip) |=> host_empty);

   a_r10_bus_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && alt_empty) |=> bus_rdata == 8'h00);
endmodule

bind pp_byte_bridge pp_byte_bridge_chk u_chk (.*);

// File: tb/pp_byte_bridge_tb_top.sv
module pp_byte_bridge_tb_top;
   localparam int CLK_P = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flip = 1'b0;
   logic        host_wr_en = 1'b0, host_wr_one = 1'b0, host_rd_en = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [15:0] host_rdata;
   logic [7:0]  bus_rdata;
   logic        host_empty, alt_empty, host_full, host_bank;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int         mcnt [2];
   int         mrp  [2];
   logic [7:0] mmem [2][DEPTH];
   int         msel;

   always #(CLK_P/2) clk = ~clk;

   pp_byte_bridge #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .flip(flip),
      .host_wr_en(host_wr_en), .host_wr_one(host_wr_one), .host_wdata(host_wdata),
      .host_rd_en(host_rd_en), .host_rdata(host_rdata),
      .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
      .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
      .host_empty(host_empty), .alt_empty(alt_empty),
      .host_full(host_full), .host_bank(host_bank)
   );

   task automatic chk(input string tg, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   task automatic model_op(input int b, input int nw, input logic [15:0] d, input int nr);
      int pre, acc, pop;
      pre = mcnt[b];
      acc = (nw > DEPTH - pre) ? DEPTH - pre : nw;
      pop = (nr > pre) ? pre : nr;
      mrp[b]  = (mrp[b] + pop) % DEPTH;
      mcnt[b] = mcnt[b] - pop;
      for (int k = 0; k < acc; k++) begin
         mmem[b][(mrp[b] + mcnt[b]) % DEPTH] = d[k*8 +: 8];
         mcnt[b]++;
      end
   endtask

   task automatic step(input bit f, input bit hw, input bit hone, input logic [15:0] hd,
                       input bit hr, input bit bw, input logic [7:0] bd, input bit br,
                       input string tg);
      int hb, ab;
      logic [15:0] eh;
      logic [7:0]  eb;
      string th, tb;
      @(negedge clk);
      flip = f; host_wr_en = hw; host_wr_one = hone; host_wdata = hd;
      host_rd_en = hr; bus_wr_en = bw; bus_wdata = bd; bus_rd_en = br;
      hb = msel; ab = 1 - msel;
      eh = '0;
      if (mcnt[hb] > 0) eh[7:0]  = mmem[hb][mrp[hb]];
      if (mcnt[hb] > 1) eh[15:8] = mmem[hb][(mrp[hb] + 1) % DEPTH];
      eb = (mcnt[ab] > 0) ? mmem[ab][mrp[ab]] : 8'h00;
      if (tg != "")             th = tg;
      else if (mcnt[hb] == 0)   th = "R9";
      else if (mcnt[hb] == 1)   th = "R4";
      else                      th = "R3";
      tb = (tg != "") ? tg : "R10";
      model_op(hb, hw ? (hone ? 1 : 2) : 0, hd, hr ? 2 : 0);
      model_op(ab, bw ? 1 : 0, {8'h00, bd}, br ? 1 : 0);
      if (f) msel = 1 - msel;
      @(posedge clk);
      #1;
      if (hr) chk(th, host_rdata, eh);
      if (br) chk(tb, {8'h00, bus_rdata}, {8'h00, eb});
      chk("R7 host_empty", {15'h0, host_empty}, {15'h0, mcnt[msel] == 0});
      chk("R7 alt_empty",  {15'h0, alt_empty},  {15'h0, mcnt[1-msel] == 0});
      chk("R8 host_full",  {15'h0, host_full},  {15'h0, mcnt[msel] == DEPTH});
      chk("R6 host_bank",  {15'h0, host_bank},  16'(msel));
   endtask

   task automatic idle();
      step(0, 0, 0, 16'h0, 0, 0, 8'h0, 0, "");
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int b = 0; b < 2; b++) begin mcnt[b] = 0; mrp[b] = 0; end
      msel = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", {12'h0, host_empty, alt_empty, host_full, host_bank}, 16'h000C);

      // R2: word order seen from the bus side after a flip
      step(0, 1, 0, 16'hBBAA, 0, 0, 8'h0, 0, "R2");
      step(1, 0, 0, 16'h0, 0, 0, 8'h0, 0, "R6");
      step(0, 0, 0, 16'h0, 0, 0, 8'h0, 1, "R2");
      step(0, 0, 0, 16'h0, 0, 0, 8'h0, 1, "R2");
      step(0, 0, 0, 16'h0, 0, 0, 8'h0, 1, "R10");

      // R5: single-byte host write
      step(0, 1, 1, 16'h77CC, 0, 0, 8'h0, 0, "R5");
      step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "R5");

      // R8 / R6 / R3 / R9: fill, overfill, double flip, drain, read empty
      for (int k = 0; k < DEPTH/2; k++)
         step(0, 1, 0, {8'(2*k+1) ^ 8'h50, 8'(2*k) ^ 8'h50}, 0, 0, 8'h0, 0, "R8");
      step(0, 1, 0, 16'hDEAD, 0, 0, 8'h0, 0, "R8");
      step(1, 0, 0, 16'h0, 0, 0, 8'h0, 0, "R6");
      step(1, 0, 0, 16'h0, 0, 0, 8'h0, 0, "R6");
      for (int k = 0; k < DEPTH/2; k++)
         step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "R3");
      step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "R9");

      // R4: odd byte count
      step(0, 1, 0, 16'h2211, 0, 0, 8'h0, 0, "");
      step(0, 1, 1, 16'h9933, 0, 0, 8'h0, 0, "");
      step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "R3");
      step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "R4");

      // R10: bus fills alternate bank, flip, host drains it
      for (int k = 0; k < 5; k++)
         step(0, 0, 0, 16'h0, 0, 1, 8'hA0 + 8'(k), 0, "R10");
      step(1, 0, 0, 16'h0, 0, 0, 8'h0, 0, "R6");
      for (int k = 0; k < 3; k++)
         step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "");

      // R8: two-byte write with one free slot keeps only the low byte
      for (int k = 0; k < DEPTH/2 - 1; k++)
         step(0, 1, 0, 16'h1000 + 16'(k), 0, 0, 8'h0, 0, "");
      step(0, 1, 1, 16'h0042, 0, 0, 8'h0, 0, "");
      step(0, 1, 0, 16'hEEFF, 0, 0, 8'h0, 0, "R8");
      for (int k = 0; k < DEPTH/2; k++)
         step(0, 0, 0, 16'h0, 1, 0, 8'h0, 0, "");
      idle();

      // R11: random mixed traffic on both sides
      for (int n = 0; n < 3000; n++) begin
         bit f, hw, hone, hr, bw, br;
         f    = ($urandom % 8) == 0;
         hw   = $urandom % 2;
         hone = ($urandom % 4) == 0;
         hr   = $urandom % 2;
         bw   = $urandom % 2;
         br   = $urandom % 2;
         step(f, hw, hone, 16'($urandom), hr, bw, 8'($urandom), br,
              ((hw || hr) && (bw || br)) ? "R11" : "");
      end
      idle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule